// File: doc/BRIEF.md
# Tensor Stream Emitter

This block takes an output tensor from a compute engine and sends it to a downstream receiver as AXI4-Stream beats. The engine hands over one group of elements per handshake. A group is exactly one bus beat wide, and the engine clock drives the handover. Groups arrive in HWC order: the channel index changes fastest, then the column, then the row. The block counts the groups against the programmed height, width and channel count. It drives to zero every element lane that lies past the channel count of the current pixel. For each beat it builds a byte strobe that covers only the real elements, and it flags the final beat of the frame. The finished beat is then written into a small dual-clock FIFO.

The receiver reads the FIFO through an AXI4-Stream master port on its own clock, and that port has its own active-low reset. A channel count that is not a multiple of the elements per beat is padded inside every pixel. Each pixel therefore closes with its own partially strobed beat. The engine side stops accepting groups while the enable input is low, while any dimension is zero, or while the FIFO is full.

Top module: `tensor_stream_emitter`

## Requirements
- R1: The engine must supply groups with the channel index changing fastest, then the column, then the row. Each pixel takes ceil(C / E) groups, where E = DATA_WIDTH / ELEM_WIDTH. Beats leave the AXI port in exactly the order they were accepted.
- R2: Element lane i occupies data bits [i*ELEM_WIDTH +: ELEM_WIDTH] and strobe bits [i*ELEM_WIDTH/8 +: ELEM_WIDTH/8]. A lane is valid when (group index within the pixel)*E + i < C. Each valid lane has all of its strobe bits set, and each invalid lane has none set. A full beat therefore carries an all-ones strobe.
- R3: The data bits of every invalid lane are zero, whatever the engine drove on them.
- R4: TLAST is high only on the last beat of the last pixel of a frame. The next accepted group starts a new frame at row 0, column 0, channel 0.
- R5: While TVALID is high and TREADY is low, TVALID, TDATA, TSTRB and TLAST hold their values. A beat transfers only on a clock edge where both are high.
- R6: While enable is low, or while height, width or channel count is zero, eng_ready is low, no group is accepted and no beat appears.
- R7: The FIFO holds 2**FIFO_AW entries (8 by default). When it is full, eng_ready is low. With TREADY held low, exactly that many groups are accepted.
- R8: After reset, TVALID is low.
- R9: With 16-bit elements, a 128-bit bus and 10 channels, each pixel gives one beat with TSTRB = 0xffff and then one beat with TSTRB = 0x000f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_eng | input | 1 | Engine-side clock |
| rst_eng_n | input | 1 | Engine-side reset, active low |
| enable | input | 1 | Allows groups to be accepted |
| cfg_height | input | DIM_W | Tensor rows |
| cfg_width | input | DIM_W | Tensor columns |
| cfg_chans | input | DIM_W | Channels per pixel |
| eng_valid | input | 1 | Engine offers a group |
| eng_data | input | DATA_WIDTH | Group of E elements, lane 0 in the low bits |
| eng_ready | output | 1 | Group accepted on this edge when eng_valid is high |
| clk_axi | input | 1 | Receiver clock |
| rst_axi_n | input | 1 | Receiver-side reset, active low |
| m_tvalid | output | 1 | Beat available |
| m_tready | input | 1 | Receiver accepts the beat |
| m_tdata | output | DATA_WIDTH | Beat data, invalid lanes zero |
| m_tstrb | output | DATA_WIDTH/8 | Byte strobe of valid lanes |
| m_tlast | output | 1 | Final beat of the frame |

## Verification
The engine-side results appear in the same cycle as the stimulus, because eng_ready is decided from registered state before the next engine edge. The bench therefore reads eng_ready 1 ns after it drives its inputs. An accepted group reaches TVALID after the engine write edge and two AXI synchronizer edges. The bench does not predict that exact edge, which depends on the phase between the clocks. Instead it queues the expected beat and compares the front of the queue on every AXI falling edge where TVALID is high. It fails any beat that has waited more than six AXI cycles with TVALID low. Hold behaviour is checked one AXI cycle after each refused beat, and the full-FIFO count is read 100 engine cycles after the producer is started against a stalled receiver.

// File: rtl/tensor_stream_emitter.sv
module tensor_stream_emitter #(
  parameter int DATA_WIDTH = 128,
  parameter int ELEM_WIDTH = 16,
  parameter int DIM_W      = 16,
  parameter int FIFO_AW    = 3
) (
  input  logic                    clk_eng,
  input  logic                    rst_eng_n,
  input  logic                    enable,
  input  logic [DIM_W-1:0]        cfg_height,
  input  logic [DIM_W-1:0]        cfg_width,
  input  logic [DIM_W-1:0]        cfg_chans,
  input  logic                    eng_valid,
  input  logic [DATA_WIDTH-1:0]   eng_data,
  output logic                    eng_ready,
  input  logic                    clk_axi,
  input  logic                    rst_axi_n,
  output logic                    m_tvalid,
  input  logic                    m_tready,
  output logic [DATA_WIDTH-1:0]   m_tdata,
  output logic [DATA_WIDTH/8-1:0] m_tstrb,
  output logic                    m_tlast
);
  localparam int ELEMS = DATA_WIDTH / ELEM_WIDTH;
  localparam int EB    = ELEM_WIDTH / 8;
  localparam int SB    = DATA_WIDTH / 8;
  localparam int CW    = DIM_W + 1;
  localparam int DEPTH = 1 << FIFO_AW;
  localparam int ENT   = DATA_WIDTH + SB + 1;

  logic [CW-1:0]      chan_base;
  logic [DIM_W-1:0]   col, row;
  logic [CW-1:0]      next_base;
  logic               last_grp, last_col, last_row, cfg_ok, full, push;
  logic [DATA_WIDTH-1:0] pix_data;
  logic [SB-1:0]         pix_strb;

  assign next_base = chan_base + CW'(ELEMS);
  assign last_grp  = next_base >= {1'b0, cfg_chans};
  assign last_col  = col == cfg_width - DIM_W'(1);
  assign last_row  = row == cfg_height - DIM_W'(1);
  assign cfg_ok    = (|cfg_height) && (|cfg_width) && (|cfg_chans);
  assign eng_ready = enable && cfg_ok && !full;
  assign push      = eng_valid && eng_ready;

  for (genvar i = 0; i < ELEMS; i++) begin : g_lane
    logic ok;
    assign ok = (chan_base + CW'(i)) < {1'b0, cfg_chans};
    assign pix_data[i*ELEM_WIDTH +: ELEM_WIDTH] = ok ? eng_data[i*ELEM_WIDTH +: ELEM_WIDTH] : '0;
    assign pix_strb[i*EB +: EB] = {EB{ok}};
  end

  always_ff @(posedge clk_eng or negedge rst_eng_n) begin
    if (!rst_eng_n) begin
      chan_base <= '0;
      col       <= '0;
      row       <= '0;
    end else if (push) begin
      if (!last_grp) begin
        chan_base <= next_base;
      end else begin
        chan_base <= '0;
        if (!last_col) begin
          col <= col + DIM_W'(1);
        end else begin
          col <= '0;
          row <= last_row ? '0 : row + DIM_W'(1);
        end
      end
    end
  end

  logic [ENT-1:0] mem [DEPTH];
  logic [FIFO_AW:0] wbin, wgray, wbin_nxt, rq1, rq2;
  logic [FIFO_AW:0] rbin, rgray, rbin_nxt, wq1, wq2;

  always_ff @(posedge clk_eng)
    if (push) mem[wbin[FIFO_AW-1:0]] <= {last_grp && last_col && last_row, pix_strb, pix_data};

  assign wbin_nxt = wbin + (FIFO_AW+1)'(push);
  assign full = wgray == {~rq2[FIFO_AW:FIFO_AW-1], rq2[FIFO_AW-2:0]};

  always_ff @(posedge clk_eng or negedge rst_eng_n) begin
    if (!rst_eng_n) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      rq1   <= rgray;
      rq2   <= rq1;
    end
  end

  assign m_tvalid = rgray != wq2;
  assign rbin_nxt = rbin + (FIFO_AW+1)'(m_tvalid && m_tready);
  assign {m_tlast, m_tstrb, m_tdata} = mem[rbin[FIFO_AW-1:0]];

  always_ff @(posedge clk_axi or negedge rst_axi_n) begin
    if (!rst_axi_n) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      wq1   <= wgray;
      wq2   <= wq1;
    end
  end
endmodule

// File: rtl/tensor_stream_emitter_chk.sv
module tensor_stream_emitter_chk #(
  parameter int DATA_WIDTH = 128,
  parameter int ELEM_WIDTH = 16
) (
  input logic                    clk_eng,
  input logic                    rst_eng_n,
  input logic                    clk_axi,
  input logic                    rst_axi_n,
  input logic                    enable,
  input logic                    eng_ready,
  input logic                    full,
  input logic                    m_tvalid,
  input logic                    m_tready,
  input logic [DATA_WIDTH-1:0]   m_tdata,
  input logic [DATA_WIDTH/8-1:0] m_tstrb,
  input logic                    m_tlast
);
  localparam int SB = DATA_WIDTH / 8;
  localparam int EB = ELEM_WIDTH / 8;

  a_r5_hold_beat: assert property (@(posedge clk_axi) disable iff (!rst_axi_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tstrb) && $stable(m_tlast));

  a_r6_gated: assert property (@(posedge clk_eng) disable iff (!rst_eng_n)
    !enable |-> !eng_ready);

  a_r7_no_overflow: assert property (@(posedge clk_eng) disable iff (!rst_eng_n)
    full |-> !eng_ready);

  a_r2_strobe_shape: assert property (@(posedge clk_axi) disable iff (!rst_axi_n)
    m_tvalid |-> m_tstrb[0] && ((m_tstrb & (m_tstrb + SB'(1))) == '0));

  a_r2_elem_grain: assert property (@(posedge clk_axi) disable iff (!rst_axi_n)
    m_tvalid |-> ($countones(m_tstrb) % EB) == 0);

  for (genvar b = 0; b < SB; b++) begin : g_byte
    a_r3_zero_lanes: assert property (@(posedge clk_axi) disable iff (!rst_axi_n)
      m_tvalid && !m_tstrb[b] |-> m_tdata[b*8 +: 8] == 8'h00);
  end
endmodule

bind tensor_stream_emitter tensor_stream_emitter_chk #(
  .DATA_WIDTH(DATA_WIDTH), .ELEM_WIDTH(ELEM_WIDTH)
) u_chk (
  .clk_eng(clk_eng), .rst_eng_n(rst_eng_n), .clk_axi(clk_axi), .rst_axi_n(rst_axi_n),
  .enable(enable), .eng_ready(eng_ready), .full(full),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
  .m_tstrb(m_tstrb), .m_tlast(m_tlast)
);

// File: tb/test_tensor_stream_emitter.sv
module test_tensor_stream_emitter;
  localparam int DW = 128;
  localparam int EW = 16;
  localparam int E  = DW / EW;
  localparam int SB = DW / 8;

  logic clk_eng = 0, clk_axi = 0, rst_eng_n = 0, rst_axi_n = 0;
  logic enable = 0, eng_valid = 0, m_tready = 0;
  logic [15:0] cfg_height = 0, cfg_width = 0, cfg_chans = 0;
  logic [DW-1:0] eng_data = '0;
  logic eng_ready, m_tvalid, m_tlast;
  logic [DW-1:0] m_tdata;
  logic [SB-1:0] m_tstrb;

  always #4 clk_axi = ~clk_axi;
  always #5.5 clk_eng = ~clk_eng;

  tensor_stream_emitter i_tensor_stream_emitter (
    .clk_eng(clk_eng), .rst_eng_n(rst_eng_n), .enable(enable),
    .cfg_height(cfg_height), .cfg_width(cfg_width), .cfg_chans(cfg_chans),
    .eng_valid(eng_valid), .eng_data(eng_data), .eng_ready(eng_ready),
    .clk_axi(clk_axi), .rst_axi_n(rst_axi_n), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tstrb(m_tstrb), .m_tlast(m_tlast));

  int checks = 0, errors = 0;
  bit done = 0;
  int ready_mode = 1;
  int accepted = 0;
  int m_g = 0, m_x = 0, m_y = 0;
  int n_full = 0, n_part = 0, n_last = 0;
  logic [DW-1:0] q_data [$];
  logic [SB-1:0] q_strb [$];
  logic          q_last [$];

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model_push(input logic [DW-1:0] d);
    logic [DW-1:0] md = '0;
    logic [SB-1:0] ms = '0;
    bit lg;
    for (int i = 0; i < E; i++)
      if (m_g * E + i < int'(cfg_chans)) begin
        md[i*EW +: EW] = d[i*EW +: EW];
        ms[i*2 +: 2] = 2'b11;
      end
    lg = (m_g + 1) * E >= int'(cfg_chans);
    q_data.push_back(md);
    q_strb.push_back(ms);
    q_last.push_back(lg && m_x == int'(cfg_width) - 1 && m_y == int'(cfg_height) - 1);
    accepted++;
    if (!lg) m_g++;
    else begin
      m_g = 0;
      if (m_x < int'(cfg_width) - 1) m_x++;
      else begin
        m_x = 0;
        m_y = (m_y < int'(cfg_height) - 1) ? m_y + 1 : 0;
      end
    end
  endfunction

  // AXI-side monitor: R1, R2, R3, R4, R5 compared on every AXI clock
  logic hold_prev = 0;
  logic [DW-1:0] p_data;
  logic [SB-1:0] p_strb;
  logic p_last;
  int lat = 0;
  always @(negedge clk_axi) begin
    if (rst_axi_n) begin
      if (hold_prev)
        check(m_tvalid && m_tdata == p_data && m_tstrb == p_strb && m_tlast == p_last,
              "R5 hold", {m_tvalid, m_tlast, m_tstrb}, {1'b1, p_last, p_strb});
      if (m_tvalid) begin
        if (q_data.size() == 0) check(0, "R1 unexpected beat", m_tdata, '0);
        else begin
          check(m_tdata == q_data[0], "R1/R3 data", m_tdata, q_data[0]);
          check(m_tstrb == q_strb[0], "R2 strobe", DW'(m_tstrb), DW'(q_strb[0]));
          check(m_tlast == q_last[0], "R4 last", DW'(m_tlast), DW'(q_last[0]));
        end
        lat = 0;
      end else if (q_data.size() != 0) begin
        lat++;
        if (lat > 6) begin
          check(0, "R1 beat missing", '0, q_data[0]);
          lat = 0;
        end
      end
      m_tready = (ready_mode == 2) ? 1'b1 : (ready_mode == 0) ? 1'b0 : 1'($urandom_range(1));
      hold_prev = m_tvalid && !m_tready;
      p_data = m_tdata; p_strb = m_tstrb; p_last = m_tlast;
      if (m_tvalid && m_tready && q_data.size() != 0) begin
        if (m_tstrb == '1) n_full++;
        if (m_tstrb == 16'h000f) n_part++;
        if (m_tlast) n_last++;
        void'(q_data.pop_front()); void'(q_strb.pop_front()); void'(q_last.pop_front());
      end
    end
  end

  task automatic send_group(input int gap_pct);
    logic [DW-1:0] d = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk_eng);
    while (int'($urandom_range(99)) < gap_pct) begin
      eng_valid = 0;
      @(negedge clk_eng);
    end
    eng_valid = 1; eng_data = d;
    #1;
    while (!eng_ready) begin
      @(negedge clk_eng); #1;
    end
    model_push(d);
  endtask

  task automatic run_frame(input int h, input int w, input int c, input int gap_pct);
    cfg_height = 16'(h); cfg_width = 16'(w); cfg_chans = 16'(c);
    for (int n = 0; n < h * w * ((c + E - 1) / E); n++) send_group(gap_pct);
    @(negedge clk_eng);
    eng_valid = 0;
  endtask

  task automatic drain();
    while (q_data.size() != 0) @(negedge clk_axi);
    repeat (8) @(negedge clk_axi);
  endtask

  initial begin
    repeat (150000) @(posedge clk_axi);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_eng);
    rst_eng_n = 1; rst_axi_n = 1;
    @(negedge clk_axi);
    check(!m_tvalid, "R8 reset tvalid", DW'(m_tvalid), '0);
    check(!eng_ready, "R6 ready while disabled", DW'(eng_ready), '0);

    // R6: enable low with a valid configuration and a pending group
    cfg_height = 2; cfg_width = 2; cfg_chans = 8;
    @(negedge clk_eng); eng_valid = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_eng); #1;
      check(!eng_ready && !m_tvalid, "R6 disabled", {eng_ready, m_tvalid}, '0);
    end
    // R6: zero channel count with enable high
    enable = 1; cfg_chans = 0;
    @(negedge clk_eng); #1;
    check(!eng_ready, "R6 zero dimension", DW'(eng_ready), '0);
    eng_valid = 0;

    // R9: 3x3x10 example, receiver always ready
    ready_mode = 2; n_full = 0; n_part = 0; n_last = 0;
    run_frame(3, 3, 10, 0); drain();
    check(n_full == 9, "R9 full strobes", DW'(n_full), DW'(9));
    check(n_part == 9, "R9 partial strobes", DW'(n_part), DW'(9));
    check(n_last == 1, "R4 one last per frame", DW'(n_last), DW'(1));

    // R1/R2: exact multiple, random backpressure
    ready_mode = 1; n_last = 0;
    run_frame(2, 2, 8, 20); drain();
    run_frame(1, 1, 1, 0); drain();
    run_frame(2, 3, 17, 30); drain();
    run_frame(3, 2, 23, 10); drain();
    check(n_last == 4, "R4 last count across frames", DW'(n_last), DW'(4));

    // R7: stalled receiver fills the FIFO
    ready_mode = 0; accepted = 0;
    fork run_frame(1, 1, 160, 0); join_none
    repeat (100) @(negedge clk_eng);
    #1;
    check(accepted == 8, "R7 accepted while stalled", DW'(accepted), DW'(8));
    check(!eng_ready, "R7 ready low when full", DW'(eng_ready), '0);
    ready_mode = 1;
    wait (accepted == 20);
    repeat (4) @(negedge clk_eng);
    drain();
    check(q_data.size() == 0, "R1 all beats delivered", DW'(q_data.size()), '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule